// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block produces the row timing for reading out a pixel matrix one row group at a time. A frame is a fixed run of row-group slots. Each slot has a fixed number of clock cycles and follows three phases that never overlap. First the gate line of the selected group is driven. While the gate is held, a one-cycle strobe tells the column digitizers to sample. Then, after at least one quiet cycle, the clear line of the same group is pulsed to empty the stored charge. The next slot moves on to the following group.

Each driver channel serves one group of rows (four matrix rows by default). The channel enables are one-hot over the channel count. The channel for a slot is the row-group index modulo the channel count, and the full index is also output so that a wider matrix can be split over several driver banks. An external trigger starts a frame from idle. At the end of a frame the block either starts the next frame with no gap or returns to idle, depending on the mode input. A trigger that arrives while a frame is running is dropped and recorded in a sticky flag.

Top module: `rs_row_sequencer`

## Requirements
- R1: While reset is asserted, and after it until the first trigger, every gate, clear and strobe output is 0, the row-group index is 0 and the overrun flag is 0.
- R2: A trigger sampled high while idle starts a frame on the next cycle. In that first cycle the frame-start output is 1, the row-group index is 0 and phase 0 of the slot is active. Frame-start is 1 in no other cycle.
- R3: With defaults, a slot is 10 cycles (phases 0 to 9). The gate enable of the selected channel is 1 in phases 0 to 5 and 0 in the other phases.
- R4: The sample strobe is 1 for one cycle per slot, in phase 4, while the gate is still held.
- R5: The clear enable of the selected channel is 1 in phases 7 and 8. Phase 6 is a quiet cycle between gate and clear. Gate and clear are never 1 in the same cycle.
- R6: The row-group index stays constant for a slot and then goes up by one. After group 127 it goes back to 0.
- R7: Frame-done is 1 for exactly one cycle: the last cycle (phase 9) of group 127.
- R8: In single mode (cont_i = 0 in the last cycle of a frame), the block goes idle after the frame. All lines stay 0 until the next trigger.
- R9: In continuous mode (cont_i = 1 in the last cycle of a frame), the next cycle is phase 0 of group 0 of a new frame, with frame-start 1.
- R10: A trigger sampled while a frame runs does not change the timing. It sets the overrun flag, which stays 1 until reset.
- R11: The selected channel is the row-group index modulo the channel count (32). At most one gate bit and at most one clear bit are 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| trig_i | input | 1 | Frame-start trigger, sampled on the rising edge |
| cont_i | input | 1 | 1: continuous frames, 0: single frame |
| gate_o | output | 32 | Per-channel gate enables |
| clear_o | output | 32 | Per-channel clear enables |
| sample_o | output | 1 | Digitizer sample strobe |
| row_o | output | 7 | Current row-group index |
| frame_start_o | output | 1 | First cycle of a frame |
| frame_done_o | output | 1 | Last cycle of a frame |
| overrun_o | output | 1 | Sticky flag for a trigger that arrived during a frame |

## Verification
The assertions check the following on every cycle:
- gate and clear are never active together, and each is one-hot at most;
- the quiet cycle after the gate falls;
- the strobe is one cycle long and falls inside the gate;
- the index only steps by one or wraps to zero;
- frame-done appears only on the last group;
- overrun is sticky.

Only the bench scenarios can show the exact phase placement inside a slot, the cycle on which a frame starts after a trigger, the single versus continuous choice at the frame boundary, and that a trigger during a frame leaves the timing unchanged.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rs_slot_timer.sv
// Cycle counter within one row-group slot and the phase windows derived from it.
module rs_slot_timer #(
  parameter int SLOT_CYC  = 10,
  parameter int GATE_END  = 6,
  parameter int SAMPLE_AT = 4,
  parameter int CLR_START = 7,
  parameter int CLR_END   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic slot_start_o,
  output logic slot_end_o,
  output logic gate_ph_o,
  output logic sample_ph_o,
  output logic clear_ph_o
);
  localparam int PH_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SLOT_CYC - 1);
  localparam logic [PH_W-1:0] PH_GEND   = PH_W'(GATE_END);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SAMPLE_AT);
  localparam logic [PH_W-1:0] PH_CSTART = PH_W'(CLR_START);
  localparam logic [PH_W-1:0] PH_CEND   = PH_W'(CLR_END);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_en;

  always_comb begin
    ph_en = run_i || (ph_q != '0);
    if (!run_i || ph_q == PH_LAST) ph_d = '0;
    else                           ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign slot_start_o = run_i && (ph_q == '0);
  assign slot_end_o   = run_i && (ph_q == PH_LAST);
  assign gate_ph_o    = run_i && (ph_q < PH_GEND);
  assign sample_ph_o  = run_i && (ph_q == PH_SAMPLE);
  assign clear_ph_o   = run_i && (ph_q >= PH_CSTART) && (ph_q < PH_CEND);
endmodule

// File: rtl/rs_frame_ctrl.sv
// Idle/run control, row-group counter, frame flags and trigger overrun.
module rs_frame_ctrl
  import rs_pkg::*;
#(
  parameter int NUM_GROUPS = 128,
  parameter int ROW_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             cont_i,
  input  logic             slot_start_i,
  input  logic             slot_end_i,
  output logic             run_o,
  output logic [ROW_W-1:0] row_o,
  output logic             frame_start_o,
  output logic             frame_done_o,
  output logic             overrun_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_GROUPS - 1);

  seq_state_e       st_q, st_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;
  logic             ovr_q, ovr_d, ovr_en;
  logic             last_slot;

  assign last_slot = (st_q == SEQ_RUN) && slot_end_i && (row_q == ROW_LAST);

  always_comb begin
    st_d   = st_q;
    row_d  = row_q;
    row_en = 1'b0;
    ovr_d  = 1'b1;
    ovr_en = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (trig_i) begin
          st_d   = SEQ_RUN;
          row_d  = '0;
          row_en = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (trig_i) ovr_en = 1'b1;
        if (slot_end_i) begin
          row_en = 1'b1;
          if (row_q == ROW_LAST) begin
            row_d = '0;
            if (!cont_i) st_d = SEQ_IDLE;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (ovr_en) ovr_q <= ovr_d;
  end

  assign run_o         = (st_q == SEQ_RUN);
  assign row_o         = row_q;
  assign frame_start_o = run_o && slot_start_i && (row_q == '0);
  assign frame_done_o  = last_slot;
  assign overrun_o     = ovr_q;
endmodule

// File: rtl/rs_line_decode.sv
// Maps the row-group index and phase windows onto one-hot channel enables.
module rs_line_decode #(
  parameter int NUM_CH = 32,
  parameter int ROW_W  = 7
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic              gate_ph_i,
  input  logic              clear_ph_i,
  output logic [NUM_CH-1:0] gate_o,
  output logic [NUM_CH-1:0] clear_o
);
  logic [ROW_W-1:0] sel;

  generate
    if (NUM_CH == 1) begin : g_single
      assign sel = '0;
    end else begin : g_multi
      assign sel = row_i % ROW_W'(NUM_CH);
    end
  endgenerate

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit        = (sel == ROW_W'(c));
    assign gate_o[c]  = gate_ph_i && hit;
    assign clear_o[c] = clear_ph_i && hit;
  end
endmodule

// File: rtl/rs_row_sequencer.sv
module rs_row_sequencer #(
  parameter int NUM_CH     = 32,
  parameter int NUM_GROUPS = 128,
  parameter int SLOT_CYC   = 10,
  parameter int GATE_END   = 6,
  parameter int SAMPLE_AT  = 4,
  parameter int CLR_START  = 7,
  parameter int CLR_END    = 9,
  localparam int ROW_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              cont_i,
  output logic [NUM_CH-1:0] gate_o,
  output logic [NUM_CH-1:0] clear_o,
  output logic              sample_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              frame_start_o,
  output logic              frame_done_o,
  output logic              overrun_o
);
  logic run, slot_start, slot_end, gate_ph, clear_ph;

  rs_slot_timer #(
    .SLOT_CYC (SLOT_CYC),
    .GATE_END (GATE_END),
    .SAMPLE_AT(SAMPLE_AT),
    .CLR_START(CLR_START),
    .CLR_END  (CLR_END)
  ) i_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run),
    .slot_start_o(slot_start),
    .slot_end_o  (slot_end),
    .gate_ph_o   (gate_ph),
    .sample_ph_o (sample_o),
    .clear_ph_o  (clear_ph)
  );

  rs_frame_ctrl #(
    .NUM_GROUPS(NUM_GROUPS),
    .ROW_W     (ROW_W)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .cont_i       (cont_i),
    .slot_start_i (slot_start),
    .slot_end_i   (slot_end),
    .run_o        (run),
    .row_o        (row_o),
    .frame_start_o(frame_start_o),
    .frame_done_o (frame_done_o),
    .overrun_o    (overrun_o)
  );

  rs_line_decode #(
    .NUM_CH(NUM_CH),
    .ROW_W (ROW_W)
  ) i_decode (
    .row_i     (row_o),
    .gate_ph_i (gate_ph),
    .clear_ph_i(clear_ph),
    .gate_o    (gate_o),
    .clear_o   (clear_o)
  );
endmodule

// File: rtl/rs_row_sequencer_chk.sv
module rs_row_sequencer_chk #(
  parameter int NUM_CH     = 32,
  parameter int NUM_GROUPS = 128,
  parameter int ROW_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              cont_i,
  input logic [NUM_CH-1:0] gate_o,
  input logic [NUM_CH-1:0] clear_o,
  input logic              sample_o,
  input logic [ROW_W-1:0]  row_o,
  input logic              frame_start_o,
  input logic              frame_done_o,
  input logic              overrun_o
);
  // R5
  gate_clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|gate_o) && (|clear_o)));
  // R5
  quiet_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|gate_o) |-> !(|clear_o));
  // R11
  gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_o));
  // R11
  clear_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clear_o));
  // R4
  sample_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (|gate_o));
  // R4
  sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);
  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_o) |-> ((row_o == ROW_W'($past(row_o) + 1'b1)) || (row_o == '0)));
  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (row_o == ROW_W'(NUM_GROUPS - 1)));
  // R2
  start_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> ((row_o == '0) && gate_o[0]));
  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun_o) |-> overrun_o);
endmodule

bind rs_row_sequencer rs_row_sequencer_chk #(
  .NUM_CH    (NUM_CH),
  .NUM_GROUPS(NUM_GROUPS),
  .ROW_W     (ROW_W)
) i_chk (.*);

// File: tb/test_rs_row_sequencer.sv
module test_rs_row_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 32;
  localparam int NGRP  = 128;
  localparam int SLOT  = 10;
  localparam int FRAME = NGRP * SLOT;
  localparam int WD_LIMIT = 190000;

  logic clk, rst_n, trig_i, cont_i;
  logic [NCH-1:0] gate_o, clear_o;
  logic sample_o, frame_start_o, frame_done_o, overrun_o;
  logic [6:0] row_o;

  int checks, errors, cycles;
  bit m_busy, m_ovr;
  int m_t;

  rs_row_sequencer i_rs_row_sequencer (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cont_i(cont_i),
    .gate_o(gate_o), .clear_o(clear_o), .sample_o(sample_o), .row_o(row_o),
    .frame_start_o(frame_start_o), .frame_done_o(frame_done_o),
    .overrun_o(overrun_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  function automatic logic [NCH-1:0] exp_gate(bit b, int t);
    if (b && (t % SLOT) < 6) return NCH'(1) << ((t / SLOT) % NCH);
    return '0;
  endfunction

  function automatic logic [NCH-1:0] exp_clear(bit b, int t);
    if (b && ((t % SLOT) == 7 || (t % SLOT) == 8)) return NCH'(1) << ((t / SLOT) % NCH);
    return '0;
  endfunction

  task automatic check_all();
    int er;
    er = m_busy ? (m_t / SLOT) : 0;
    chk(row_o == 7'(er), "R6 R9 row index", row_o, er);
    chk(gate_o == exp_gate(m_busy, m_t), "R3 R8 R11 gate", gate_o, exp_gate(m_busy, m_t));
    chk(clear_o == exp_clear(m_busy, m_t), "R5 R11 clear", clear_o, exp_clear(m_busy, m_t));
    chk(sample_o == (m_busy && (m_t % SLOT) == 4), "R4 sample", sample_o,
        m_busy && (m_t % SLOT) == 4);
    chk(frame_start_o == (m_busy && m_t == 0), "R2 frame start", frame_start_o,
        m_busy && m_t == 0);
    chk(frame_done_o == (m_busy && m_t == FRAME - 1), "R7 frame done", frame_done_o,
        m_busy && m_t == FRAME - 1);
    chk(overrun_o == m_ovr, "R10 overrun", overrun_o, m_ovr);
  endtask

  // One clock: drive inputs at the falling edge, advance the model, check at the next falling edge.
  task automatic cyc(input bit t, input bit m);
    bit nb, no;
    int nt;
    trig_i = t;
    cont_i = m;
    nb = m_busy; nt = m_t; no = m_ovr;
    if (!m_busy) begin
      if (t) begin nb = 1'b1; nt = 0; end
    end else begin
      if (t) no = 1'b1;
      if (m_t == FRAME - 1) begin
        nt = 0;
        if (!m) nb = 1'b0;
      end else nt = m_t + 1;
    end
    @(posedge clk);
    @(negedge clk);
    m_busy = nb; m_t = nt; m_ovr = no;
    check_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    checks = 0; errors = 0; cycles = 0;
    m_busy = 0; m_ovr = 0; m_t = 0;
    rst_n = 1'b0; trig_i = 1'b0; cont_i = 1'b0;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state, with a trigger held high during reset
    trig_i = 1'b1;
    @(negedge clk);
    check_all();
    chk(gate_o == '0 && clear_o == '0, "R1 lines in reset", {gate_o, clear_o}, 0);
    trig_i = 1'b0;
    rst_n = 1'b1;
    cyc(0, 0);
    cyc(0, 0);

    // R2 R8 single frame, then idle
    cyc(1, 0);
    chk(frame_start_o && gate_o == NCH'(1), "R2 first cycle", {frame_start_o, gate_o}, 33'h1_0000_0001);
    for (int i = 1; i < FRAME; i++) cyc(0, 0);
    chk(frame_done_o, "R7 last cycle", frame_done_o, 1);
    for (int i = 0; i < 25; i++) cyc(0, 0);
    chk(gate_o == '0 && clear_o == '0 && !sample_o, "R8 idle after single", gate_o, 0);

    // R9 continuous: two frames back to back, then stop
    cyc(1, 1);
    for (int i = 1; i < FRAME; i++) cyc(0, 1);
    cyc(0, 1);
    chk(frame_start_o && row_o == 0, "R9 back-to-back start", frame_start_o, 1);
    for (int i = 1; i < FRAME; i++) cyc(0, 0);
    cyc(0, 0);
    chk(!frame_start_o && gate_o == '0, "R8 stop after continuous", gate_o, 0);

    // R10 trigger mid-frame: timing unchanged, overrun sticks
    cyc(1, 0);
    for (int i = 1; i < 503; i++) cyc(0, 0);
    cyc(1, 0);
    chk(overrun_o, "R10 overrun set", overrun_o, 1);
    for (int i = 504; i < FRAME; i++) cyc(0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0);
    chk(overrun_o && gate_o == '0, "R10 overrun held, idle", {overrun_o, gate_o}, 33'h1_0000_0000);

    // Constrained random traffic
    for (int it = 0; it < 40; it++) begin
      bit m;
      int len;
      m = ($urandom % 3) == 0;
      len = 20 + ($urandom % 1500);
      for (int k = 0; k < len; k++) begin
        bit t;
        t = (!m_busy && ($urandom % 40) == 0) || ($urandom % 500) == 0;
        cyc(t, m);
      end
    end

    // R1 reset clears everything including overrun
    @(negedge clk);
    rst_n = 1'b0;
    m_busy = 0; m_t = 0; m_ovr = 0;
    #1;
    check_all();
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0);
    chk(!overrun_o && row_o == 0, "R1 after second reset", overrun_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule